// File: doc/BRIEF.md
# Frame Slip and Repeat Detector

This block sits beside the output buffer of a digital audio receiver whose serial output port is clocked by an external left/right clock. It runs in the 256x sample-rate clock domain. It takes a one-cycle strobe at the start of every incoming frame, meaning the preamble that opens the first channel of the frame. It compares these strobes with the active edges of the external left/right clock, which are brought into the domain through a synchronizer.

A fixed, short delay after each frame strobe, the block counts the active edges seen since its previous evaluation. If there were no edges, the output side fell behind. The buffer is told to present the previous frame again, and a slip is reported. If there were two or more edges, the output side ran ahead, and one incoming frame is lost. If there was exactly one edge, everything is in step. Every reported event sets a sticky status flag, which a read strobe clears, and also produces a one-cycle interrupt pulse.

An edge that sits very close to the frame boundary can jitter from one side of it to the other. A hysteresis rule keeps this from producing a stream of alternating events. After any event, and after reset, reporting is disarmed. It is armed again only when an active edge lands well inside the frame, away from the boundary band.

Top module: `slip_repeat_detector`

## Requirements
- R1: While reset is high, and on the first cycle after it, `slip_flag`, `irq_pulse`, `reuse_prev` and `frame_lost` are all 0, and reporting is disarmed.
- R2: The left/right clock passes through `SYNC_STAGES` flops (default 2) before edge detection. The active edge is the rising edge when `lr_fall_active` is 0 and the falling edge when it is 1. Edges of the other direction are not counted.
- R3: An evaluation takes place `EVAL_DLY` cycles (default 4) after `frame_stb` is sampled high. It judges the active edges counted since the previous evaluation. Any outputs it produces appear as registers one cycle later, so with the defaults the pulse is visible 5 cycles after the strobe.
- R4: If an armed evaluation counts zero active edges, it reports a slip. `irq_pulse` and `reuse_prev` are high for exactly one cycle, and `slip_flag` becomes 1.
- R5: If an armed evaluation counts two or more active edges, it reports a lost frame. `irq_pulse` and `frame_lost` are high for one cycle, `reuse_prev` stays 0, and `slip_flag` becomes 1.
- R6: An evaluation that counts exactly one active edge reports nothing and leaves `slip_flag` unchanged.
- R7: `slip_flag` is sticky. It stays 1 until a cycle with `status_rd` high, after which it reads 0. It rises only together with `irq_pulse`.
- R8: If an event is reported in the same cycle as a read strobe, the event wins and `slip_flag` stays 1.
- R9: Every reported event, and reset, disarms reporting. An evaluation that would report while disarmed produces no outputs. Reporting is armed again by an active edge whose phase, counted in cycles from the latest frame strobe, lies between `FRAME_CYC*HYST_PCT/100` and `FRAME_CYC - FRAME_CYC*HYST_PCT/100` inclusive. With the defaults this range is 71 to 185.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 256x sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe at the start of each incoming frame |
| lr_clk | input | 1 | External left/right clock, asynchronous to clk |
| lr_fall_active | input | 1 | 0: rising edge is active, 1: falling edge is active |
| status_rd | input | 1 | Read strobe that clears the sticky flag |
| slip_flag | output | 1 | Sticky flag set by a slip or a lost frame |
| irq_pulse | output | 1 | One-cycle pulse for each reported event |
| reuse_prev | output | 1 | One-cycle command to output the previous frame again |
| frame_lost | output | 1 | One-cycle pulse when a frame has been dropped |

## Verification
The edge counter and the arming bit are internal. A wrong count shows up at the next evaluation, at most one frame later, as an event of the wrong kind, as a missing `irq_pulse`, or as an extra one. A wrong arming state shows up either as a second event after a jittery boundary frame or as a real slip that is never reported. The tests therefore build frames with zero, one and two active edges and place those edges inside and outside the arming range. They use both edge polarities, and they read every event at the port outputs within one frame.

// File: rtl/srd_pkg.sv
package srd_pkg;

    // Outcome of one evaluation of an inter-frame interval
    typedef enum logic [1:0] {
        JDG_NONE = 2'd0,
        JDG_SLIP = 2'd1,
        JDG_LOST = 2'd2
    } judge_e;

    typedef struct packed {
        logic   hit;
        judge_e kind;
    } verdict_t;

    // Edge count (saturating at 2) to outcome
    function automatic judge_e judge_of(input logic [1:0] n);
        if (n == 2'd0)      return JDG_SLIP;
        else if (n == 2'd1) return JDG_NONE;
        else                return JDG_LOST;
    endfunction

    // Width of a cycle counter spanning one frame plus headroom
    function automatic int phase_width(input int frame_cyc);
        return $clog2(frame_cyc) + 1;
    endfunction

endpackage

// File: rtl/srd_edge_sync.sv
module srd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lr_async,
    input  logic fall_active,
    output logic act_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], lr_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign act_edge = fall_active ? (prev_q & ~sync_q[STAGES-1])
                                  : (~prev_q & sync_q[STAGES-1]);
endmodule

// File: rtl/srd_frame_timer.sv
module srd_frame_timer #(
    parameter int FRAME_CYC = 256,
    parameter int EVAL_DLY  = 4,
    parameter int PH_W      = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    output logic            eval,
    output logic [PH_W-1:0] phase
);
    localparam int DLY_W = $clog2(EVAL_DLY + 1);

    logic [PH_W-1:0]  phase_q;
    logic [DLY_W-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            dly_q   <= '0;
        end else if (frame_stb) begin
            phase_q <= '0;
            dly_q   <= DLY_W'(EVAL_DLY);
        end else begin
            if (phase_q != '1) phase_q <= phase_q + 1'b1;
            if (dly_q != '0)   dly_q   <= dly_q - 1'b1;
        end
    end

    assign eval  = (dly_q == DLY_W'(1));
    assign phase = phase_q;
endmodule

// File: rtl/srd_judge.sv
module srd_judge
    import srd_pkg::*;
#(
    parameter int FRAME_CYC = 256,
    parameter int HYST_PCT  = 28,
    parameter int PH_W      = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act_edge,
    input  logic [PH_W-1:0] phase,
    input  logic            eval,
    output verdict_t        verdict
);
    localparam int BAND   = FRAME_CYC * HYST_PCT / 100;
    localparam int ARM_LO = BAND;
    localparam int ARM_HI = FRAME_CYC - BAND;

    logic [1:0] cnt_q;
    logic       armed_q;
    logic       mid_edge;

    assign mid_edge = act_edge && (phase >= PH_W'(ARM_LO)) && (phase <= PH_W'(ARM_HI));

    always_comb begin
        verdict.kind = judge_of(cnt_q);
        verdict.hit  = eval && armed_q && (verdict.kind != JDG_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= 2'd0;
            armed_q <= 1'b0;
        end else begin
            if (eval)
                cnt_q <= act_edge ? 2'd1 : 2'd0;
            else if (act_edge && cnt_q != 2'd2)
                cnt_q <= cnt_q + 2'd1;

            if (verdict.hit)
                armed_q <= 1'b0;
            else if (mid_edge)
                armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/slip_repeat_detector.sv
module slip_repeat_detector
    import srd_pkg::*;
#(
    parameter int FRAME_CYC   = 256,
    parameter int EVAL_DLY    = 4,
    parameter int HYST_PCT    = 28,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic lr_clk,
    input  logic lr_fall_active,
    input  logic status_rd,
    output logic slip_flag,
    output logic irq_pulse,
    output logic reuse_prev,
    output logic frame_lost
);
    localparam int PH_W = phase_width(FRAME_CYC);

    logic            act_edge;
    logic            eval;
    logic [PH_W-1:0] phase;
    verdict_t        verdict;

    srd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .lr_async    (lr_clk),
        .fall_active (lr_fall_active),
        .act_edge    (act_edge)
    );

    srd_frame_timer #(.FRAME_CYC(FRAME_CYC), .EVAL_DLY(EVAL_DLY), .PH_W(PH_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .eval      (eval),
        .phase     (phase)
    );

    srd_judge #(.FRAME_CYC(FRAME_CYC), .HYST_PCT(HYST_PCT), .PH_W(PH_W)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .act_edge (act_edge),
        .phase    (phase),
        .eval     (eval),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slip_flag  <= 1'b0;
            irq_pulse  <= 1'b0;
            reuse_prev <= 1'b0;
            frame_lost <= 1'b0;
        end else begin
            irq_pulse  <= verdict.hit;
            reuse_prev <= verdict.hit && (verdict.kind == JDG_SLIP);
            frame_lost <= verdict.hit && (verdict.kind == JDG_LOST);
            // a new event outranks a simultaneous read
            if (verdict.hit)    slip_flag <= 1'b1;
            else if (status_rd) slip_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/srd_checker.sv
module srd_checker (
    input logic clk,
    input logic rst,
    input logic status_rd,
    input logic slip_flag,
    input logic irq_pulse,
    input logic reuse_prev,
    input logic frame_lost
);
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    assert_reuse_with_irq_R4: assert property (@(posedge clk) disable iff (rst)
        reuse_prev |-> irq_pulse);

    assert_lost_with_irq_R5: assert property (@(posedge clk) disable iff (rst)
        frame_lost |-> (irq_pulse && !reuse_prev));

    assert_irq_has_kind_R6: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (reuse_prev || frame_lost));

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (slip_flag && !status_rd) |=> slip_flag);

    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(slip_flag) |-> irq_pulse);

    assert_read_vs_set_R8: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> (slip_flag == irq_pulse));

    assert_flag_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> slip_flag);
endmodule

bind slip_repeat_detector srd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .status_rd  (status_rd),
    .slip_flag  (slip_flag),
    .irq_pulse  (irq_pulse),
    .reuse_prev (reuse_prev),
    .frame_lost (frame_lost)
);

// File: tb/slip_repeat_detector_test.sv
`timescale 1ns/1ps
module slip_repeat_detector_test;
    localparam int FRAME = 256;
    localparam int EVAL  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 1'b0;
    logic lr_clk = 1'b0;
    logic lr_fall_active = 1'b0;
    logic status_rd = 1'b0;
    logic slip_flag, irq_pulse, reuse_prev, frame_lost;

    int checks = 0;
    int fails  = 0;
    int cyc = 0;
    int stb_cyc = 0;
    int irq_cyc = 0;
    int n_irq = 0, n_reuse = 0, n_lost = 0;
    logic lr_lvl = 1'b0;
    bit done = 1'b0;

    slip_repeat_detector uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .lr_clk(lr_clk),
        .lr_fall_active(lr_fall_active), .status_rd(status_rd),
        .slip_flag(slip_flag), .irq_pulse(irq_pulse),
        .reuse_prev(reuse_prev), .frame_lost(frame_lost)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_pulse) begin n_irq++; irq_cyc = cyc; end
            if (reuse_prev) n_reuse++;
            if (frame_lost) n_lost++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one frame: strobe at cycle 0, lr_clk toggles at the listed cycles
    task automatic run_frame(input int t0 = -1, input int t1 = -1, input int t2 = -1,
                             input int t3 = -1, input int rd_at = -1);
        for (int c = 0; c < FRAME; c++) begin
            @(negedge clk);
            frame_stb = (c == 0);
            status_rd = (c == rd_at);
            if (c == 0) stb_cyc = cyc;
            if (c == t0 || c == t1 || c == t2 || c == t3) begin
                lr_lvl = !lr_lvl;
                lr_clk = lr_lvl;
            end
        end
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 flag in reset", slip_flag, 0);
        check("R1 irq in reset", irq_pulse, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", {slip_flag, irq_pulse, reuse_prev, frame_lost}, 0);
    endtask

    task automatic t_steady();
        for (int i = 0; i < 4; i++) run_frame(100, 228);
        check("R9 disarmed start no event", n_irq, 0);
        check("R6 one edge no flag", slip_flag, 0);
    endtask

    task automatic t_slip();
        int i0 = n_irq, r0 = n_reuse, l0 = n_lost;
        run_frame();
        run_frame(100, 228);
        check("R4 slip irq", n_irq - i0, 1);
        check("R4 slip reuse", n_reuse - r0, 1);
        check("R4 slip no lost", n_lost - l0, 0);
        check("R4 slip flag", slip_flag, 1);
        check("R3 eval latency", irq_cyc - stb_cyc, EVAL + 1);
    endtask

    task automatic t_sticky();
        int i0 = n_irq;
        run_frame(100, 228);
        run_frame(100, 228);
        check("R7 flag held", slip_flag, 1);
        check("R6 no new event", n_irq - i0, 0);
        run_frame(100, 228, -1, -1, 150);
        check("R7 read clears", slip_flag, 0);
    endtask

    task automatic t_lost();
        int i0 = n_irq, r0 = n_reuse, l0 = n_lost;
        run_frame(40, 80, 160, 200);
        run_frame(100, 228);
        check("R5 lost irq", n_irq - i0, 1);
        check("R5 lost pulse", n_lost - l0, 1);
        check("R5 no reuse", n_reuse - r0, 0);
        check("R5 lost flag", slip_flag, 1);
        run_frame(100, 228, -1, -1, 150);
        check("R7 clear after lost", slip_flag, 0);
    endtask

    task automatic t_hyst();
        int i0 = n_irq, r0 = n_reuse, l0 = n_lost;
        run_frame();                 // no edge: slip reported next
        run_frame(190, 200, 230, 240); // two edges near boundary only
        run_frame(100, 228);         // rearms
        run_frame(100, 228);
        check("R9 one event only", n_irq - i0, 1);
        check("R9 suppressed lost", n_lost - l0, 0);
        check("R9 slip reuse", n_reuse - r0, 1);
        run_frame();
        run_frame(100, 228, -1, -1, 150);
        check("R9 rearmed reports", n_irq - i0, 2);
        run_frame(100, 228, -1, -1, 150);
        check("R7 clear after hyst", slip_flag, 0);
    endtask

    task automatic t_prio();
        int i0 = n_irq;
        run_frame();
        run_frame(100, 228, -1, -1, EVAL);
        check("R8 set wins over read", slip_flag, 1);
        check("R8 event seen", n_irq - i0, 1);
        run_frame(100, 228, -1, -1, 150);
        check("R7 later read clears", slip_flag, 0);
    endtask

    task automatic t_pol();
        int i0 = n_irq, r0 = n_reuse;
        lr_fall_active = 1'b1;
        run_frame(20, 100);
        run_frame(20, 100);
        run_frame(128);              // rising only
        run_frame(100);              // falling, mid
        run_frame(20, 100);
        check("R2 falling mode slip", n_irq - i0, 1);
        check("R2 falling mode reuse", n_reuse - r0, 1);
        run_frame(20, 100, -1, -1, 150);
        check("R2 flag cleared", slip_flag, 0);
        lr_fall_active = 1'b0;
        i0 = n_irq;
        run_frame(100, 228);
        run_frame(100, 228);
        run_frame(128);              // rising only counts once
        run_frame(50, 100, 228);
        run_frame(100, 228);
        run_frame(100, 228);
        check("R2 rising mode no event", n_irq - i0, 0);
        check("R2 rising mode flag", slip_flag, 0);
    endtask

    initial begin
        t_reset();
        t_steady();
        t_slip();
        t_sticky();
        t_lost();
        t_hyst();
        t_prio();
        t_pol();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule